// File: doc/BRIEF.md
# Serial Register Command Interpreter

This block sits behind a byte-wide serial front end and turns a stream of command bytes into accesses to a file of sixteen 8-bit control registers. Each byte the front end delivers comes with a one-cycle `in_vld` strobe. A command is an opcode byte, optionally followed by a count byte. The opcode's upper nibble selects the operation and its lower nibble gives the first register. The low nibble of the count byte holds the number of registers minus one.

A read burst puts register contents on `dout`, one register for each transfer that follows the count byte, in rising address order. A write burst takes the bytes that follow the count byte and stores them in rising address order. Both bursts wrap from register 15 back to register 0. A dedicated single-byte opcode clears the continuous-output flag, which the conversion side raises with `cont_start`. Every other opcode is passed unchanged to an external engine (for example the bank-copy logic) as a one-cycle dispatch pulse.

Top module: `regcmd_interp`

## Requirements
- R1: After reset `byte_req`, `dout_vld`, `wr_en`, `disp_vld` and `cont_mode` are 0, `dout` is 0, and every register reads back as 0.
- R2: An opcode of the form 0x1r followed by a count byte with low nibble n starts a read of n+1 registers from register r. From the cycle after the count byte is accepted, `dout` holds the current register and `dout_vld` is 1. Each later accepted byte moves `dout` to the next register. After the last of the n+1 transfers, `dout_vld` returns to 0.
- R3: An opcode of the form 0x5r followed by a count byte with low nibble n starts a write of n+1 registers from register r. While each data byte is presented with `in_vld` high, `wr_en` is 1 and `wr_addr`/`wr_data` carry the register and the byte in that same cycle. The register holds the new value from the next clock edge.
- R4: In both burst types the address after register 15 is register 0.
- R5: The upper nibble of the count byte has no effect on either command.
- R6: Bytes accepted during a read burst never change any register.
- R7: Opcode 0x0F clears `cont_mode` and causes neither a dispatch nor a write. A `cont_start` pulse sets `cont_mode` at the next edge. If both happen in the same cycle, the clear wins.
- R8: Any other opcode (every value other than 0x0F, 0x1x or 0x5x) makes `disp_vld` 1 for exactly the one cycle after it is accepted, with `disp_op` equal to the opcode. The interpreter stays idle.
- R9: `byte_req` is 1 from the cycle after a read or write opcode is accepted until the cycle after the last byte of its burst is accepted, and 0 otherwise.
- R10: Cycles with `in_vld` low change nothing: `dout` stays the same, `wr_en` is 0 and the burst position is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Byte strobe from the serial front end |
| in_byte | input | 8 | Received byte |
| byte_req | output | 1 | More bytes are needed to finish the current command |
| dout | output | 8 | Byte to shift out on the next transfer |
| dout_vld | output | 1 | `dout` holds register data |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 4 | Register being written |
| wr_data | output | 8 | Value being written |
| disp_vld | output | 1 | Opcode handed to the external engine |
| disp_op | output | 8 | Dispatched opcode |
| cont_start | input | 1 | Sets the continuous-output flag |
| cont_mode | output | 1 | Continuous-output flag |

## Verification
The hardest situation to reach from the ports is a burst that crosses from register 15 to register 0 while the count byte carries a non-zero don't-care nibble. The stimulus gets there by sweeping every start register against every length for reads, and every start register for writes, with the count byte's upper nibble derived from the loop indices. Whether filler bytes during a read leave the registers untouched is checked only by a later full read of all sixteen registers. That read is compared against a model the bench keeps from its own writes.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GET_COUNT,
    ST_READ_BURST,
    ST_WRITE_BURST
  } st_e;

  typedef enum logic [1:0] {
    OPK_READ,
    OPK_WRITE,
    OPK_STOP,
    OPK_OTHER
  } opk_e;

  localparam logic [3:0] READ_NIB  = 4'h1;
  localparam logic [3:0] WRITE_NIB = 4'h5;
  localparam logic [7:0] STOP_CODE = 8'h0F;

  // Opcode class from the upper nibble, stop code matched in full
  function automatic opk_e classify(input logic [7:0] op);
    if (op == STOP_CODE)          return OPK_STOP;
    else if (op[7:4] == READ_NIB) return OPK_READ;
    else if (op[7:4] == WRITE_NIB) return OPK_WRITE;
    else                          return OPK_OTHER;
  endfunction

  // Burst address step; the register space is a power of two so it wraps
  function automatic logic [3:0] step_addr(input logic [3:0] a);
    return a + 4'd1;
  endfunction

endpackage

// File: rtl/regcmd_decode.sv
module regcmd_decode
  import regcmd_pkg::*;
(
  input  logic [7:0] op,
  output opk_e       kind,
  output logic [3:0] start_reg
);
  always_comb begin
    kind      = classify(op);
    start_reg = op[3:0];
  end
endmodule

// File: rtl/regcmd_regfile.sv
module regcmd_regfile #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_q[g] <= '0;
      else if (we && waddr == ADDR_W'(g))
        regs_q[g] <= wdata;
    end
  end

  assign rdata = regs_q[raddr];
endmodule

// File: rtl/regcmd_interp.sv
module regcmd_interp
  import regcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_vld,
  input  logic [7:0] in_byte,
  output logic       byte_req,
  output logic [7:0] dout,
  output logic       dout_vld,
  output logic       wr_en,
  output logic [3:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       disp_vld,
  output logic [7:0] disp_op,
  input  logic       cont_start,
  output logic       cont_mode
);
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  st_e               st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] cnt_q;
  logic              is_rd_q;
  logic [DATA_W-1:0] dout_q;
  logic              disp_q;
  logic [7:0]        disp_op_q;
  logic              cont_q;

  opk_e              op_kind;
  logic [ADDR_W-1:0] op_reg;
  logic [ADDR_W-1:0] rf_raddr;
  logic [DATA_W-1:0] rf_rdata;

  // Named events
  logic opcode_take;
  logic count_take;
  logic burst_take;
  logic burst_last;
  logic [ADDR_W-1:0] addr_nxt;

  regcmd_decode u_dec (
    .op        (in_byte),
    .kind      (op_kind),
    .start_reg (op_reg)
  );

  assign opcode_take = in_vld && (st_q == ST_IDLE);
  assign count_take  = in_vld && (st_q == ST_GET_COUNT);
  assign burst_take  = in_vld && (st_q == ST_READ_BURST || st_q == ST_WRITE_BURST);
  assign burst_last  = burst_take && (cnt_q == '0);
  assign addr_nxt    = step_addr(addr_q);

  assign wr_en   = in_vld && (st_q == ST_WRITE_BURST);
  assign wr_addr = addr_q;
  assign wr_data = in_byte;

  // Read port looks at the first register on the count byte, then one ahead
  assign rf_raddr = (st_q == ST_GET_COUNT) ? addr_q : addr_nxt;

  regcmd_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      cnt_q     <= '0;
      is_rd_q   <= 1'b0;
      dout_q    <= '0;
      disp_q    <= 1'b0;
      disp_op_q <= '0;
      cont_q    <= 1'b0;
    end else begin
      disp_q <= 1'b0;
      if (cont_start) cont_q <= 1'b1;
      if (opcode_take) begin
        unique case (op_kind)
          OPK_READ: begin
            addr_q  <= op_reg;
            is_rd_q <= 1'b1;
            st_q    <= ST_GET_COUNT;
          end
          OPK_WRITE: begin
            addr_q  <= op_reg;
            is_rd_q <= 1'b0;
            st_q    <= ST_GET_COUNT;
          end
          OPK_STOP: cont_q <= 1'b0;
          default: begin
            disp_q    <= 1'b1;
            disp_op_q <= in_byte;
          end
        endcase
      end
      if (count_take) begin
        cnt_q <= in_byte[ADDR_W-1:0];
        if (is_rd_q) begin
          st_q   <= ST_READ_BURST;
          dout_q <= rf_rdata;
        end else begin
          st_q <= ST_WRITE_BURST;
        end
      end
      if (burst_take) begin
        if (burst_last) begin
          st_q <= ST_IDLE;
        end else begin
          addr_q <= addr_nxt;
          cnt_q  <= cnt_q - 1'b1;
          if (st_q == ST_READ_BURST) dout_q <= rf_rdata;
        end
      end
    end
  end

  assign byte_req  = (st_q != ST_IDLE);
  assign dout      = dout_q;
  assign dout_vld  = (st_q == ST_READ_BURST);
  assign disp_vld  = disp_q;
  assign disp_op   = disp_op_q;
  assign cont_mode = cont_q;
endmodule

// File: rtl/regcmd_chk.sv
module regcmd_chk
  import regcmd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       in_vld,
  input logic [7:0] in_byte,
  input st_e        st_q,
  input logic       dout_vld,
  input logic [7:0] dout,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic       disp_vld,
  input logic [7:0] disp_op,
  input logic       cont_mode
);
  // R8
  disp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_vld |-> $past(in_vld) && disp_op == $past(in_byte));

  // R4
  write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> wr_addr == $past(wr_addr) + 4'd1);

  // R7
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && st_q == ST_IDLE && in_byte == STOP_CODE) |=> !cont_mode);

  // R10
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_vld && !in_vld) |=> $stable(dout) && dout_vld);

  // R2
  read_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_vld) |-> $past(in_vld) && $past(st_q) == ST_GET_COUNT);

  // R6
  no_write_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |-> !wr_en);
endmodule

bind regcmd_interp regcmd_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_vld    (in_vld),
  .in_byte   (in_byte),
  .st_q      (st_q),
  .dout_vld  (dout_vld),
  .dout      (dout),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .disp_vld  (disp_vld),
  .disp_op   (disp_op),
  .cont_mode (cont_mode)
);

// File: tb/regcmd_interp_test.sv
`timescale 1ns/1ps
module regcmd_interp_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_vld = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       cont_start = 1'b0;
  logic       byte_req, dout_vld, wr_en, disp_vld, cont_mode;
  logic [7:0] dout, wr_data, disp_op;
  logic [3:0] wr_addr;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [16];
  logic       s_wr_en;
  logic [3:0] s_wr_addr;
  logic [7:0] s_wr_data;

  always #4 clk = ~clk;

  regcmd_interp uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
    .byte_req(byte_req), .dout(dout), .dout_vld(dout_vld),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .disp_vld(disp_vld), .disp_op(disp_op),
    .cont_start(cont_start), .cont_mode(cont_mode)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Present one byte for one clock; capture the combinational write port
  task automatic send(input logic [7:0] b);
    in_vld = 1'b1;
    in_byte = b;
    #1;
    s_wr_en = wr_en;
    s_wr_addr = wr_addr;
    s_wr_data = wr_data;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int s, input int k);
    return 8'((s * 37 + k * 11 + 3) ^ 8'hA5);
  endfunction

  task automatic do_read(input int s, input int n, input logic [3:0] hi, input logic [7:0] filler);
    send({4'h1, 4'(s)});
    check(byte_req == 1'b1, "R9 req after read opcode", byte_req, 1);
    send({hi, 4'(n)});
    for (int k = 0; k <= n; k++) begin
      check(dout_vld == 1'b1, "R2 dout_vld in burst", dout_vld, 1);
      check(dout == model[(s + k) % 16], "R2/R4/R5 read data", dout, model[(s + k) % 16]);
      send(filler);
    end
    check(dout_vld == 1'b0, "R2 dout_vld after burst", dout_vld, 0);
    check(byte_req == 1'b0, "R9 req after read burst", byte_req, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(byte_req == 0, "R1 byte_req", byte_req, 0);
    check(dout_vld == 0, "R1 dout_vld", dout_vld, 0);
    check(wr_en == 0, "R1 wr_en", wr_en, 0);
    check(disp_vld == 0, "R1 disp_vld", disp_vld, 0);
    check(cont_mode == 0, "R1 cont_mode", cont_mode, 0);
    check(dout == 0, "R1 dout", dout, 0);
    do_read(0, 15, 4'h0, 8'h00);

    // R3 R4 R5 write sweep: start s, length s+1, don't-care nibble varies
    for (int s = 0; s < 16; s++) begin
      send({4'h5, 4'(s)});
      check(byte_req == 1, "R9 req after write opcode", byte_req, 1);
      send({4'(15 - s), 4'(s)});
      for (int k = 0; k <= s; k++) begin
        send(pat(s, k));
        check(s_wr_en == 1, "R3 wr_en", s_wr_en, 1);
        check(s_wr_addr == 4'((s + k) % 16), "R3/R4 wr_addr", s_wr_addr, (s + k) % 16);
        check(s_wr_data == pat(s, k), "R3 wr_data", s_wr_data, pat(s, k));
        model[(s + k) % 16] = pat(s, k);
        if (k == 2) begin
          // R10 idle cycles mid write
          in_byte = 8'hEE;
          #1;
          check(wr_en == 0, "R10 no write when idle", wr_en, 0);
          repeat (2) @(negedge clk);
        end
      end
      check(byte_req == 0, "R9 req after write burst", byte_req, 0);
    end

    // R2 R4 R5 R6 read sweep over all starts and lengths
    for (int s = 0; s < 16; s++)
      for (int n = 0; n < 16; n++)
        do_read(s, n, 4'(s ^ n), {4'h5, 4'(n)});
    // R6 filler bytes left registers intact
    do_read(0, 15, 4'hF, 8'h0F);

    // R10 dout held while no byte arrives
    send(8'h13);
    send(8'h02);
    repeat (3) @(negedge clk);
    check(dout == model[3], "R10 dout held", dout, model[3]);
    send(8'h00);
    check(dout == model[4], "R10 burst position kept", dout, model[4]);
    send(8'h00);
    send(8'h00);
    check(dout_vld == 0, "R2 burst end after hold", dout_vld, 0);

    // R7 continuous flag
    cont_start = 1'b1;
    @(negedge clk);
    cont_start = 1'b0;
    check(cont_mode == 1, "R7 set by cont_start", cont_mode, 1);
    send(8'h0F);
    check(cont_mode == 0, "R7 cleared by stop", cont_mode, 0);
    check(disp_vld == 0, "R7 no dispatch on stop", disp_vld, 0);
    check(s_wr_en == 0, "R7 no write on stop", s_wr_en, 0);
    cont_start = 1'b1;
    send(8'h0F);
    cont_start = 1'b0;
    check(cont_mode == 0, "R7 clear wins", cont_mode, 0);
    send(8'h0F);
    check(cont_mode == 0, "R7 stays clear", cont_mode, 0);

    // R8 dispatch sweep over every remaining opcode
    for (int v = 0; v < 256; v++) begin
      if (v == 8'h0F || v[7:4] == 4'h1 || v[7:4] == 4'h5) continue;
      send(8'(v));
      check(disp_vld == 1, "R8 disp_vld", disp_vld, 1);
      check(disp_op == 8'(v), "R8 disp_op", disp_op, v);
      check(byte_req == 0, "R8 stays idle", byte_req, 0);
      @(negedge clk);
      check(disp_vld == 0, "R8 single cycle", disp_vld, 0);
    end
    do_read(7, 15, 4'h9, 8'hC3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule